// File: doc/BRIEF.md
# Synchronous Serial Master/Slave Shifter

This block moves one 8-bit word in each direction at once over a three-wire serial link: a serial clock, a transmit data line and a receive data line. As a master it makes the serial clock by dividing the system clock. As a slave it takes the serial clock from outside, passes it through a synchronizer into the system clock domain and acts on the edges it finds there. Bits go out and come in most-significant first.

A polarity setting chooses the clock's resting level, and the resting level fixes the two edges. The edge that leaves the resting level launches the next transmit bit. The edge that returns to it samples the receive line. With positive polarity the clock rests high, so the falling edge launches and the rising edge samples. With negative polarity the clock rests low, so the rising edge launches and the falling edge samples. After eight bits the clock is back at its resting level, and the transmit line keeps the last bit it sent.

The parallel side has a start strobe, a busy flag, a one-cycle done pulse and the received byte. Mode, polarity and divider are taken at the moment a start is accepted. Software must keep the serial clock period at or above 66.67 ns. In slave mode the system clock must run at least four times faster than the serial clock.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, busy, done and txd are 0, sck_oe is 0 (slave), and sck_out rests high (positive polarity).
- R2: A transfer sends tx_byte on txd most-significant bit first and puts the 8 bits read from rxd, first bit received in bit 7, on rx_byte.
- R3: With cfg_pol=1 (positive), txd changes only on falling serial clock edges and rxd is sampled on rising edges.
- R4: After a transfer the serial clock rests high when cfg_pol=1 and low when cfg_pol=0.
- R5: With cfg_pol=0 (negative), txd changes on rising serial clock edges and rxd is sampled on falling edges.
- R6: While busy is 0, txd holds the last bit sent, i.e. bit 0 of the previous tx_byte.
- R7: With cfg_master=1 each serial clock half-period lasts cfg_half_div system clocks (0 acts as 1), so done rises 16*max(cfg_half_div,1) clocks after the clock edge that takes the start.
- R8: With cfg_master=0 the transfer is clocked by sck_in, in both polarities, with rxd sampled through the same synchronizer delay as sck_in.
- R9: done is high for exactly one system clock after the eighth sample edge, busy falls in that same cycle, and rx_byte holds the received word from that cycle on.
- R10: A start pulse while busy is 1 is ignored and produces no extra transfer.
- R11: sck_oe is 1 exactly when the mode captured at the last accepted start is master (cfg_master=1), and it changes only when a start is accepted.
- R12: cfg_master, cfg_pol and cfg_half_div are captured when a start is accepted; later changes have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master (drive sck_out), 0 = slave (use sck_in) |
| cfg_pol | input | 1 | 1 = positive polarity (rest high), 0 = negative (rest low) |
| cfg_half_div | input | DIV_W | Master half-period in system clocks, 0 treated as 1 |
| start | input | 1 | Start request, taken when busy is 0 |
| tx_byte | input | DATA_W | Word to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |
| rx_byte | output | DATA_W | Received word |
| sck_in | input | 1 | Serial clock from outside (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_out |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
In master mode the only latency is the divider. done is due 16*max(cfg_half_div,1) system clocks after the edge that takes the start. The bench counts falling system clock edges from the start pulse to done and compares the count with that figure for half-periods 0, 1, 2 and 3. In slave mode done comes three system clocks after the last returning edge of sck_in, because of the two synchronizer flops and the edge register. There the bench bounds the wait instead of counting. Each received word is queued before its start, and a monitor pops the queue on the cycle done is high. A peer model reads txd on the returning clock edge and checks it against the word sent.

// File: rtl/sss_pkg.sv
package sss_pkg;

   typedef enum logic {
      SSS_SLAVE  = 1'b0,
      SSS_MASTER = 1'b1
   } sss_mode_e;

   // One-cycle strobes marking serial clock edges in the system clock domain.
   typedef struct packed {
      logic launch;   // edge leaving the resting level
      logic sample;   // edge returning to the resting level
   } sss_evt_t;

endpackage

// File: rtl/sss_master_clkgen.sv
module sss_master_clkgen
   import sss_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   input  logic             pol,
   output sss_evt_t         evt,
   output logic             sck_level
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] half_eff;
   logic             phase;   // 1 while away from the resting level
   logic             tick;

   assign half_eff = (half_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_div;
   assign tick     = run && (cnt == half_eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (tick) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   assign evt.launch = tick && !phase;
   assign evt.sample = tick &&  phase;
   assign sck_level  = pol ? ~phase : phase;

endmodule

// File: rtl/sss_slave_sync.sv
module sss_slave_sync
   import sss_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sck_in,
   input  logic     rxd_in,
   input  logic     pol,
   output sss_evt_t evt,
   output logic     rxd_out
);

   logic [STAGES-1:0] sck_sh;
   logic [STAGES-1:0] rxd_sh;
   logic              sck_prev;
   logic              rise;
   logic              fall;

   // Data follows the same number of stages as the clock so both stay aligned.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sh   <= '0;
         rxd_sh   <= '0;
         sck_prev <= 1'b0;
      end else begin
         sck_sh   <= {sck_sh[STAGES-2:0], sck_in};
         rxd_sh   <= {rxd_sh[STAGES-2:0], rxd_in};
         sck_prev <= sck_sh[STAGES-1];
      end
   end

   assign rise       =  sck_sh[STAGES-1] & ~sck_prev;
   assign fall       = ~sck_sh[STAGES-1] &  sck_prev;
   assign evt.launch = pol ? fall : rise;
   assign evt.sample = pol ? rise : fall;
   assign rxd_out    = rxd_sh[STAGES-1];

endmodule

// File: rtl/sss_shift_core.sv
module sss_shift_core
   import sss_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_take,
   input  logic [DATA_W-1:0] tx_byte,
   input  sss_evt_t          evt,
   input  logic              rxd_bit,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              txd
);

   localparam int                CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] rx_next;
   logic [CNT_W-1:0]  bit_cnt;

   assign rx_next = {rx_sh[DATA_W-2:0], rxd_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_byte <= '0;
         bit_cnt <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         txd     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_take) begin
            tx_sh   <= tx_byte;
            bit_cnt <= '0;
            busy    <= 1'b1;
         end else if (busy) begin
            if (evt.launch) begin
               txd   <= tx_sh[DATA_W-1];
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (evt.sample) begin
               rx_sh <= rx_next;
               if (bit_cnt == LAST) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  rx_byte <= rx_next;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
   import sss_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SLAVE_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_pol,
   input  logic [DIV_W-1:0]  cfg_half_div,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              txd,
   input  logic              rxd
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("sync_serial_xcvr: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div_w
      $error("sync_serial_xcvr: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sync_serial_xcvr: SYNC_STAGES must be at least 2");
   end

   sss_mode_e        mode_q;
   logic             pol_q;
   logic [DIV_W-1:0] div_q;
   logic             start_take;
   sss_evt_t         m_evt;
   sss_evt_t         s_evt;
   sss_evt_t         evt;
   logic             m_level;
   logic             s_rxd;
   logic             rxd_bit;
   logic             is_master;

   assign start_take = start && !busy;
   assign is_master  = (mode_q == SSS_MASTER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SSS_SLAVE;
         pol_q  <= 1'b1;
         div_q  <= '0;
      end else if (start_take) begin
         mode_q <= (SLAVE_EN && !cfg_master) ? SSS_SLAVE : SSS_MASTER;
         pol_q  <= cfg_pol;
         div_q  <= cfg_half_div;
      end
   end

   sss_master_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy && is_master),
      .half_div  (div_q),
      .pol       (pol_q),
      .evt       (m_evt),
      .sck_level (m_level)
   );

   if (SLAVE_EN) begin : g_slave
      sss_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .sck_in  (sck_in),
         .rxd_in  (rxd),
         .pol     (pol_q),
         .evt     (s_evt),
         .rxd_out (s_rxd)
      );
   end else begin : g_no_slave
      assign s_evt = '0;
      assign s_rxd = 1'b0;
   end

   assign evt     = is_master ? m_evt : s_evt;
   assign rxd_bit = is_master ? rxd   : s_rxd;

   sss_shift_core #(.DATA_W(DATA_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_take (start_take),
      .tx_byte    (tx_byte),
      .evt        (evt),
      .rxd_bit    (rxd_bit),
      .busy       (busy),
      .done       (done),
      .rx_byte    (rx_byte),
      .txd        (txd)
   );

   assign sck_out = is_master ? m_level : pol_q;
   assign sck_oe  = is_master;

endmodule

// File: rtl/sss_chk.sv
module sss_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic txd,
   input logic sck_out,
   input logic sck_oe,
   input logic pol_q
);

   // R9
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R6
   txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(txd));

   // R4
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sck_oe) |-> (sck_out == pol_q));

   // R11
   oe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && !busy) |=> $stable(sck_oe));

endmodule

bind sync_serial_xcvr sss_chk u_sss_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .txd     (txd),
   .sck_out (sck_out),
   .sck_oe  (sck_oe),
   .pol_q   (pol_q)
);

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_master = 1'b0;
   logic       cfg_pol = 1'b1;
   logic [7:0] cfg_half_div = 8'd1;
   logic       start = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       busy, done, sck_out, sck_oe, txd;
   logic [7:0] rx_byte;
   logic       sck_in = 1'b1;
   logic       rxd = 1'b0;

   int tests = 0;
   int fails = 0;
   logic [7:0] exp_q[$];
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sync_serial_xcvr i_sync_serial_xcvr (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
      .cfg_half_div(cfg_half_div), .start(start), .tx_byte(tx_byte),
      .busy(busy), .done(done), .rx_byte(rx_byte), .sck_in(sck_in),
      .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd), .rxd(rxd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   // Monitor: pops the scoreboard on each done cycle.
   logic done_d = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10 unexpected transfer", rx_byte, 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rx_byte == e, "R2/R9 rx_byte at done", rx_byte, e);
               chk(busy == 1'b0, "R9 busy low with done", busy, 0);
            end
            chk(!done_d, "R9 done one cycle", done_d, 0);
         end
         done_d <= done;
      end
   end

   // Master transfer with a bench peer acting as slave.
   task automatic run_master(input bit pol, input logic [7:0] div, input logic [7:0] tx,
                             input logic [7:0] peer, input bit disturb);
      logic [7:0] cap = '0;
      int cyc = 0;
      int neff = (div == 0) ? 1 : int'(div);
      @(negedge clk);
      cfg_master = 1'b1; cfg_pol = pol; cfg_half_div = div; tx_byte = tx;
      exp_q.push_back(peer);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      fork
         begin
            for (int i = 0; i < 8; i++) begin
               wait (sck_out != pol);
               #1 rxd = peer[7-i];
               wait (sck_out == pol);
               #1 cap = {cap[6:0], txd};
            end
         end
         begin
            while (cyc < 5000) begin
               @(negedge clk);
               cyc++;
               if (done) break;
            end
         end
         begin
            if (disturb) begin
               repeat (6) @(negedge clk);
               start = 1'b1; tx_byte = ~tx; cfg_pol = ~pol; cfg_half_div = 8'd7;
               cfg_master = 1'b0;
               @(negedge clk);
               start = 1'b0;
            end
         end
      join
      chk(cyc == 16 * neff, "R7 master done latency", cyc, 16 * neff);
      chk(cap == tx, pol ? "R2/R3 txd MSB first" : "R2/R5 txd MSB first", cap, tx);
      chk(sck_out == pol, "R4 resting level", sck_out, pol);
      chk(sck_oe == 1'b1, "R11 master oe", sck_oe, 1);
      repeat (5) @(negedge clk);
      chk(txd == tx[0], "R6 txd holds last bit", txd, tx[0]);
      chk(sck_out == pol, "R4 still resting", sck_out, pol);
      if (disturb) chk(busy == 1'b0, "R10/R12 no extra transfer", busy, 0);
   endtask

   // Slave transfer with the bench driving sck_in.
   task automatic run_slave(input bit pol, input int half, input logic [7:0] tx,
                            input logic [7:0] peer);
      logic [7:0] cap = '0;
      int wt = 0;
      @(negedge clk);
      cfg_master = 1'b0; cfg_pol = pol; sck_in = pol; tx_byte = tx;
      repeat (4) @(negedge clk);
      exp_q.push_back(peer);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(sck_oe == 1'b0, "R11 slave oe", sck_oe, 0);
      for (int i = 0; i < 8; i++) begin
         repeat (half) @(negedge clk);
         sck_in = ~pol;
         rxd = peer[7-i];
         repeat (half) @(negedge clk);
         cap = {cap[6:0], txd};
         sck_in = pol;
      end
      while (!done && wt < 10) begin
         @(negedge clk);
         wt++;
      end
      chk(wt <= 4, "R8 slave done after last edge", wt, 3);
      chk(cap == tx, "R8 slave txd MSB first", cap, tx);
      repeat (4) @(negedge clk);
      chk(txd == tx[0], "R6 slave txd holds", txd, tx[0]);
      chk(sck_out == pol, "R4 slave resting output", sck_out, pol);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(txd == 1'b0, "R1 txd", txd, 0);
      chk(sck_oe == 1'b0, "R1 sck_oe", sck_oe, 0);
      chk(sck_out == 1'b1, "R1 sck_out", sck_out, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_master(1'b1, 8'd2, 8'hA5, 8'h3C, 1'b0);   // R3 positive
      run_master(1'b0, 8'd1, 8'h96, 8'hC3, 1'b0);   // R5 negative
      run_master(1'b1, 8'd0, 8'h01, 8'hFE, 1'b0);   // R7 zero divider
      run_master(1'b0, 8'd3, 8'h5A, 8'h81, 1'b1);   // R10 R12 disturbed
      run_master(1'b1, 8'd1, 8'hFF, 8'h00, 1'b0);
      run_slave (1'b1, 6, 8'h4B, 8'hD2);            // R8 positive
      run_slave (1'b0, 5, 8'hE1, 8'h17);            // R8 negative
      run_master(1'b0, 8'd2, 8'h00, 8'hFF, 1'b0);   // back to master, R11

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R9 every transfer completed", exp_q.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

endmodule